// File: doc/BRIEF.md
# Memory-Mapped Block Storage Ports

This block puts two word-wide ports at fixed addresses on a processor bus. Together they give word-serial access to a backing store that is organized in blocks of 128 words of 32 bits each. The streaming port is at one address. A bus write to it chooses a block. Each bus read after that returns the next word of the block, and when one block ends the port carries on into the following block by itself. The fill port is at a second address. The first bus write to it names the block that will be overwritten. The 128 bus writes after that become the words of that block, in order. The port then goes back to waiting for a new block number. A bus read of the fill port always returns zero.

The block drives the backing store through a plain interface: a block index, a word offset, write data and a write strobe, with read data coming back. Every store access finishes in the same cycle as the bus beat that causes it. The bus is a single-beat request channel made up of a valid qualifier, a write flag, an address and write data. The block accepts every beat in the cycle it is presented, so it never applies back-pressure and has no ready output. Read data is returned combinationally during the beat. Only one port can be accessed per cycle. Beats to any other address leave both ports unchanged.

Top module: `blkstore_ports`

## Requirements
- R1: After reset, both block numbers are 0 and both word offsets are 0. The fill port is waiting for a block number, so the first read of the streaming address returns word 0 of block 0.
- R2: A bus write to the streaming address loads the low block-number bits of the write data as the read block and sets the read offset to 0. It causes no store write.
- R3: Each bus read of the streaming address presents the current read block and offset on the store index and offset, returns the store read data on `bus_rdata` in the same cycle, and then advances the offset by one.
- R4: A read of the streaming address at offset 127 is followed by a read at offset 0 of the block number plus one.
- R5: When the fill port is waiting, a bus write to the fill address loads the low block-number bits of the write data as the write block, sets the write offset to 0, and does not assert the store write strobe.
- R6: While the fill port is streaming, each bus write to the fill address asserts the store write strobe for one cycle, with the write data, the write block and the current offset (offsets 0 to 127 in order). After offset 127 the port waits for a block number again.
- R7: A bus read of the fill address returns 0, does not write the store, and changes no port state.
- R8: A beat to any other address, or a cycle without `bus_valid`, returns 0 on `bus_rdata`, does not write the store, and leaves both ports' block numbers, offsets and fill state unchanged.
- R9: `bus_rdata` is zero whenever the current beat is not a read of the streaming address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus beat is present this cycle |
| bus_write | input | 1 | 1 = write beat, 0 = read beat |
| bus_addr | input | ADDR_W | Beat address |
| bus_wdata | input | DATA_W | Write data, or block number when a port is loaded |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the beat |
| st_blk | output | BLK_W | Block index presented to the store |
| st_off | output | OFF_W | Word offset within the block presented to the store |
| st_rdata | input | DATA_W | Combinational read data from the store |
| st_wdata | output | DATA_W | Write data to the store |
| st_we | output | 1 | Store write strobe, one word per cycle |

## Verification
The assertions assume that `bus_addr`, `bus_write` and `bus_wdata` are known whenever `bus_valid` is high, and that the store returns its read word in the same cycle it is indexed. The bench changes inputs only at falling edges and holds each beat for exactly one rising edge. It returns the store word as an arithmetic function of the index and offset, so every streamed word can be predicted. The bench never offers more than one beat per cycle, which matches the rule that the two ports are not accessed together.

// File: rtl/blkstore_pkg.sv
package blkstore_pkg;

  typedef enum logic {
    FILL_AWAIT_BLK = 1'b0,
    FILL_STREAM    = 1'b1
  } fill_state_e;

  typedef struct packed {
    logic strm_rd;
    logic strm_wr;
    logic fill_rd;
    logic fill_wr;
  } beat_kind_t;

endpackage

// File: rtl/blkstore_decode.sv
module blkstore_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] STRM_ADDR = '1,
  parameter logic [ADDR_W-1:0] FILL_ADDR = '0
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output blkstore_pkg::beat_kind_t kind
);
  logic hit_strm;
  logic hit_fill;

  always_comb begin
    hit_strm     = bus_valid && (bus_addr == STRM_ADDR);
    hit_fill     = bus_valid && (bus_addr == FILL_ADDR);
    kind.strm_rd = hit_strm && !bus_write;
    kind.strm_wr = hit_strm &&  bus_write;
    kind.fill_rd = hit_fill && !bus_write;
    kind.fill_wr = hit_fill &&  bus_write;
  end
endmodule

// File: rtl/blkstore_strm.sv
module blkstore_strm #(
  parameter int BLK_W = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_blk,
  input  logic             step,
  output logic [BLK_W-1:0] blk,
  output logic [OFF_W-1:0] off
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  logic at_end;
  assign at_end = (off == LAST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk <= '0;
      off <= '0;
    end else if (load) begin
      blk <= load_blk;
      off <= '0;
    end else if (step) begin
      if (at_end) begin
        off <= '0;
        blk <= blk + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blkstore_fill.sv
module blkstore_fill #(
  parameter int BLK_W = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [BLK_W-1:0] beat_blk,
  output logic [BLK_W-1:0] blk,
  output logic [OFF_W-1:0] off,
  output blkstore_pkg::fill_state_e state,
  output logic             store_we
);
  import blkstore_pkg::*;
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  assign store_we = beat && (state == FILL_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk   <= '0;
      off   <= '0;
      state <= FILL_AWAIT_BLK;
    end else if (beat) begin
      if (state == FILL_AWAIT_BLK) begin
        blk   <= beat_blk;
        off   <= '0;
        state <= FILL_STREAM;
      end else if (off == LAST_OFF) begin
        off   <= '0;
        state <= FILL_AWAIT_BLK;
      end else begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blkstore_ports.sv
module blkstore_ports #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 16,
  parameter int WORDS_PER_BLK = 128,
  parameter int OFF_W  = $clog2(WORDS_PER_BLK),
  parameter logic [ADDR_W-1:0] STRM_ADDR = 32'hFFFF_FFF8,
  parameter logic [ADDR_W-1:0] FILL_ADDR = 32'hFFFF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BLK_W-1:0]  st_blk,
  output logic [OFF_W-1:0]  st_off,
  input  logic [DATA_W-1:0] st_rdata,
  output logic [DATA_W-1:0] st_wdata,
  output logic              st_we
);
  import blkstore_pkg::*;

  beat_kind_t       kind;
  logic [BLK_W-1:0] rd_blk;
  logic [OFF_W-1:0] rd_off;
  logic [BLK_W-1:0] wr_blk;
  logic [OFF_W-1:0] wr_off;
  fill_state_e      wr_state;
  logic [BLK_W-1:0] beat_blk;

  assign beat_blk = bus_wdata[BLK_W-1:0];

  blkstore_decode #(
    .ADDR_W(ADDR_W), .STRM_ADDR(STRM_ADDR), .FILL_ADDR(FILL_ADDR)
  ) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .kind(kind)
  );

  blkstore_strm #(.BLK_W(BLK_W), .OFF_W(OFF_W)) u_strm (
    .clk(clk), .rst_n(rst_n),
    .load(kind.strm_wr), .load_blk(beat_blk), .step(kind.strm_rd),
    .blk(rd_blk), .off(rd_off)
  );

  blkstore_fill #(.BLK_W(BLK_W), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .beat(kind.fill_wr), .beat_blk(beat_blk),
    .blk(wr_blk), .off(wr_off), .state(wr_state), .store_we(st_we)
  );

  always_comb begin
    if (kind.strm_rd) begin
      st_blk = rd_blk;
      st_off = rd_off;
    end else begin
      st_blk = wr_blk;
      st_off = wr_off;
    end
    st_wdata  = bus_wdata;
    bus_rdata = kind.strm_rd ? st_rdata : '0;
  end
endmodule

// File: rtl/blkstore_ports_chk.sv
module blkstore_ports_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 16,
  parameter int OFF_W  = 7,
  parameter logic [ADDR_W-1:0] STRM_ADDR = '1,
  parameter logic [ADDR_W-1:0] FILL_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              st_we,
  input logic [BLK_W-1:0]  rd_blk,
  input logic [OFF_W-1:0]  rd_off,
  input logic [BLK_W-1:0]  wr_blk,
  input logic [OFF_W-1:0]  wr_off,
  input logic              wr_state
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  logic strm_rd, fill_rd, fill_wr, other;
  assign strm_rd = bus_valid && !bus_write && (bus_addr == STRM_ADDR);
  assign fill_rd = bus_valid && !bus_write && (bus_addr == FILL_ADDR);
  assign fill_wr = bus_valid &&  bus_write && (bus_addr == FILL_ADDR);
  assign other   = !bus_valid || ((bus_addr != STRM_ADDR) && (bus_addr != FILL_ADDR));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_blk == '0 && rd_off == '0 && wr_off == '0 && wr_state == 1'b0));

  assert_strm_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_rd && rd_off == LAST_OFF) |=>
      (rd_off == '0 && rd_blk == BLK_W'($past(rd_blk) + 1'b1)));

  assert_fill_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && wr_state && wr_off == LAST_OFF) |=> (wr_state == 1'b0));

  assert_fill_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rd |-> (bus_rdata == '0 && !st_we));

  assert_fill_rd_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rd |=> ($stable(wr_blk) && $stable(wr_off) && $stable(wr_state)
                 && $stable(rd_blk) && $stable(rd_off)));

  assert_other_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> ($stable(rd_blk) && $stable(rd_off) && $stable(wr_blk)
               && $stable(wr_off) && $stable(wr_state)));

  assert_we_only_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> fill_wr);

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strm_rd |-> (bus_rdata == '0));
endmodule

bind blkstore_ports blkstore_ports_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .OFF_W(OFF_W),
  .STRM_ADDR(STRM_ADDR), .FILL_ADDR(FILL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .st_we(st_we),
  .rd_blk(rd_blk), .rd_off(rd_off), .wr_blk(wr_blk), .wr_off(wr_off),
  .wr_state(wr_state)
);

// File: tb/blkstore_ports_tb.sv
module blkstore_ports_tb;
  localparam logic [31:0] SA = 32'hFFFF_FFF8;
  localparam logic [31:0] FA = 32'hFFFF_FFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [15:0] st_blk;
  logic [6:0]  st_off;
  logic [31:0] st_rdata, st_wdata;
  logic        st_we;

  int checks = 0, errors = 0, we_count = 0;
  logic [31:0] wmem [0:3][0:127];

  always #2 clk = ~clk;

  blkstore_ports u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_blk(st_blk), .st_off(st_off), .st_rdata(st_rdata),
    .st_wdata(st_wdata), .st_we(st_we)
  );

  function automatic logic [31:0] word_of(input int b, input int o);
    return 32'(b * 1000 + o * 3 + 7);
  endfunction

  assign st_rdata = word_of(int'(st_blk), int'(st_off));

  always @(posedge clk) if (st_we) begin
    we_count <= we_count + 1;
    if (st_blk < 16'd4) wmem[st_blk[1:0]][st_off] <= st_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] s_rdata;
  logic        s_we;

  task automatic beat(input logic [31:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = w; bus_wdata = d;
    #1;
    s_rdata = bus_rdata;
    s_we    = st_we;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check(bus_rdata == 32'd0, "R9 idle rdata", bus_rdata, 32'd0);

    // R1: first streamed word after reset is block 0 word 0
    beat(SA, 1'b0, '0);
    check(s_rdata == word_of(0, 0), "R1 reset read", s_rdata, word_of(0, 0));

    // R2: load block 2, no store write
    beat(SA, 1'b1, 32'd2);
    check(!s_we, "R2 no we", {31'd0, s_we}, 32'd0);
    // R3 / R4 sweep across two boundaries
    for (int i = 0; i < 300; i++) begin
      beat(SA, 1'b0, '0);
      check(s_rdata == word_of(2 + i / 128, i % 128), (i % 128 == 0 && i > 0) ? "R4 wrap" : "R3 stream",
            s_rdata, word_of(2 + i / 128, i % 128));
    end
    // R2 restart mid-block
    beat(SA, 1'b1, 32'd5);
    beat(SA, 1'b0, '0);
    check(s_rdata == word_of(5, 0), "R2 restart", s_rdata, word_of(5, 0));

    // R5: block number for the fill port
    beat(FA, 1'b1, 32'd1);
    check(!s_we, "R5 no we", {31'd0, s_we}, 32'd0);
    for (int i = 0; i < 128; i++) begin
      beat(FA, 1'b1, 32'hA000_0000 + 32'(i));
      check(s_we, "R6 we", {31'd0, s_we}, 32'd1);
    end
    // R7: fill read is zero
    beat(FA, 1'b0, '0);
    check(s_rdata == 32'd0 && !s_we, "R7 zero", s_rdata, 32'd0);
    // R6: next write is a new block number
    beat(FA, 1'b1, 32'd3);
    check(!s_we, "R6 back to await", {31'd0, s_we}, 32'd0);
    beat(FA, 1'b1, 32'hB000_0000);
    beat(FA, 1'b1, 32'hB000_0001);
    // R8: other address has no effect
    beat(32'h0000_1000, 1'b1, 32'd9);
    check(!s_we && s_rdata == 32'd0, "R8 other write", {31'd0, s_we}, 32'd0);
    beat(32'h0000_1000, 1'b0, '0);
    check(s_rdata == 32'd0, "R8 other read", s_rdata, 32'd0);
    beat(FA, 1'b1, 32'hB000_0002);
    beat(SA, 1'b0, '0);
    check(s_rdata == word_of(5, 1), "R8 stream kept", s_rdata, word_of(5, 1));
    idle();
    @(negedge clk);

    for (int i = 0; i < 128; i++)
      check(wmem[1][i] == 32'hA000_0000 + 32'(i), "R6 block1 data", wmem[1][i], 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 3; i++)
      check(wmem[3][i] == 32'hB000_0000 + 32'(i), "R6 block3 data", wmem[3][i], 32'hB000_0000 + 32'(i));
    check(we_count == 131, "R8 write count", 32'(we_count), 32'd131);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule